// File: doc/BRIEF.md
# Pipeline Hazard and Branch Control

This block is the interlock and steering logic for a five-stage in-order integer pipeline. The stages run fetch, decode, register read, ALU and writeback, in that order. Each cycle the fetch side gives the block a short descriptor of the instruction just fetched: its tag, its source registers and their use flags, its destination register and write enable, and three class bits. The class bits are late result, shared-port user and branch. The block keeps its own copy of these descriptors for the decode, register-read, ALU and writeback stages. From that copy it decides when fetch must hold, when bubbles go in, which source the register-read stage takes each operand from, and which wrong-path instructions are dropped.

Two inputs select the operating mode. With forwarding enabled, the ALU output and the writeback value are steered to the operands of the instruction in register read. Only a result that arrives late costs a cycle. With forwarding disabled, a dependent instruction waits in decode until its producer is in writeback. A branch is resolved in the ALU stage. In squash mode a taken branch discards the three younger instructions. In delayed mode the one instruction right behind the branch runs to completion and only the two after it are discarded.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While reset is held, and right after it, every stage is empty: wb_valid=0, hold_fetch=0, redirect=0, and fwd_a=fwd_b=0.
- R2: With no hazards, an instruction presented at fetch in cycle t shows up at writeback (wb_valid=1, wb_tag equal to its tag) in cycle t+4, in program order.
- R3: With fwd_en=0, a consumer that is d instructions behind a producer of a nonzero register is held in decode for max(0, 3-d) cycles, and both select outputs stay at 0 (register file).
- R4: With fwd_en=1, operand select code 1 means ALU-stage result and code 2 means writeback value. A consumer in register read gets code 1 when its producer is in the ALU stage and code 2 when the producer is in writeback, with no stall.
- R5: With fwd_en=1, a late-result producer directly ahead of its consumer costs one stall cycle, after which the operand takes code 2.
- R6: When both the ALU stage and writeback write the register an operand needs, the select is code 1, the younger producer.
- R7: Register 0 is never a dependency: a write to it never stalls and never gives a nonzero select code.
- R8: An instruction in the ALU stage that uses the shared memory port raises hold_fetch for that cycle. The instruction at fetch is not taken and is fetched again in the next cycle.
- R9: In squash mode (delay_mode=0), a branch in the ALU stage with ex_cond=1 raises redirect for one cycle. The three younger instructions never reach writeback, and the target is fetched in the next cycle.
- R10: In delayed mode (delay_mode=1), a taken branch keeps the one instruction fetched right after it, which reaches writeback. The next two instructions are discarded.
- R11: ex_cond has no effect unless the ALU-stage instruction is a branch, and a branch with ex_cond=0 drops nothing.
- R12: A discarded instruction leaves a bubble with its write enable cleared. It never reaches writeback and never causes a forward select or a stall for a later reader of its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | 1 = operand forwarding enabled |
| delay_mode | input | 1 | 1 = delayed-branch slot, 0 = full squash |
| if_valid | input | 1 | A real instruction is at fetch |
| if_tag | input | 8 | Identifier carried down the pipeline |
| if_rs1 | input | 5 | First source register |
| if_use1 | input | 1 | First source is read |
| if_rs2 | input | 5 | Second source register |
| if_use2 | input | 1 | Second source is read |
| if_rd | input | 5 | Destination register |
| if_we | input | 1 | Destination is written |
| if_late | input | 1 | Result not ready at the end of the ALU stage |
| if_mem | input | 1 | Uses the shared memory port in the ALU stage |
| if_br | input | 1 | Conditional branch |
| ex_cond | input | 1 | Branch outcome computed by the ALU this cycle |
| hold_fetch | output | 1 | Keep the fetch address; the current fetch is not taken |
| redirect | output | 1 | Taken branch; fetch the target next cycle |
| fwd_a | output | 2 | Source of operand 1 in register read (0 file, 1 ALU, 2 writeback) |
| fwd_b | output | 2 | Source of operand 2 in register read |
| wb_valid | output | 1 | A real instruction is in writeback |
| wb_tag | output | 8 | Tag of the writeback instruction |
| wb_rd | output | 5 | Destination register of the writeback instruction |
| wb_we | output | 1 | Register-file write enable |

## Verification
The bench sweeps producer-to-consumer distance from one to four. For each distance it tries both operand ports, both forwarding settings, normal and late producers, and a zero or nonzero destination. In every case it computes the retire cycle and the select code due in the consumer's register-read cycle. A comparison that counts the writeback stage as a hazard adds a stall here, a missing register-0 guard stalls on r0, and a wrong priority order picks the older producer when two stages write the same register. The branch tests run one program in squash, delayed and not-taken form. A slot instruction that is dropped wrongly, a killed instruction that still retires, or a redirect raised on ex_cond without a branch each changes the set of retired tags or their timing. A structural-hazard case checks that the fetch held back by a shared-port user is replayed once rather than lost.

// File: rtl/phc_pkg.sv
package phc_pkg;

    localparam int RA_W  = 5;
    localparam int TAG_W = 8;
    localparam int N_SRC = 2;
    localparam int SEL_W = 2;

    typedef logic [RA_W-1:0] reg_addr_t;

    typedef enum logic [SEL_W-1:0] {
        SRC_RF = 2'd0,
        SRC_EX = 2'd1,
        SRC_WB = 2'd2
    } fwd_src_e;

    typedef struct packed {
        logic                        vld;
        logic [TAG_W-1:0]            tag;
        reg_addr_t [N_SRC-1:0]       rs;
        logic [N_SRC-1:0]            use_rs;
        reg_addr_t                   rd;
        logic                        we;
        logic                        late;
        logic                        mem;
        logic                        br;
    } slot_t;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        reg_addr_t        rd;
        logic             we;
    } wb_t;

    // true when a stage holding (vld, we, rd) produces register r
    function automatic logic writes_reg(input logic vld, input logic we,
                                        input reg_addr_t rd, input reg_addr_t r);
        return vld && we && (rd != '0) && (rd == r);
    endfunction

    // consumer c reads some register that producer p writes
    function automatic logic depends_on(input slot_t c, input slot_t p);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < N_SRC; k++) begin
            hit = hit | (c.use_rs[k] & writes_reg(p.vld, p.we, p.rd, c.rs[k]));
        end
        return hit;
    endfunction

    // operand source for one read port, youngest producer first
    function automatic fwd_src_e pick_src(input logic en, input logic used,
                                          input reg_addr_t r,
                                          input slot_t ex, input wb_t wb);
        fwd_src_e s;
        s = SRC_RF;
        if (en && used) begin
            if (writes_reg(ex.vld, ex.we, ex.rd, r)) begin
                s = SRC_EX;
            end else if (writes_reg(wb.vld, wb.we, wb.rd, r)) begin
                s = SRC_WB;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/phc_stage_regs.sv
module phc_stage_regs
    import phc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t if_slot,
    input  logic  hold_dec,
    input  logic  kill_if,
    input  logic  kill_dec,
    input  logic  kill_rr,
    output slot_t id_q,
    output slot_t rr_q,
    output slot_t ex_q,
    output wb_t   wb_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q <= '0;
            rr_q <= '0;
            ex_q <= '0;
            wb_q <= '0;
        end else begin
            if (!hold_dec) begin
                id_q <= kill_if ? '0 : if_slot;
            end
            rr_q <= kill_dec ? '0 : id_q;
            ex_q <= kill_rr ? '0 : rr_q;
            wb_q.vld <= ex_q.vld;
            wb_q.tag <= ex_q.tag;
            wb_q.rd  <= ex_q.rd;
            wb_q.we  <= ex_q.we;
        end
    end

endmodule

// File: rtl/phc_stall_unit.sv
module phc_stall_unit
    import phc_pkg::*;
(
    input  logic  fwd_en,
    input  slot_t id_q,
    input  slot_t rr_q,
    input  slot_t ex_q,
    output logic  data_stall,
    output logic  port_busy
);

    logic raw_rr;
    logic raw_ex;

    always_comb begin
        raw_rr = depends_on(id_q, rr_q);
        raw_ex = depends_on(id_q, ex_q);
        if (fwd_en) begin
            // only a result that is not ready after the ALU stage must wait
            data_stall = raw_rr & rr_q.late;
        end else begin
            // wait until the producer has reached writeback
            data_stall = raw_rr | raw_ex;
        end
        port_busy = ex_q.vld & ex_q.mem;
    end

endmodule

// File: rtl/phc_fwd_unit.sv
module phc_fwd_unit
    import phc_pkg::*;
(
    input  logic                        fwd_en,
    input  slot_t                       rr_q,
    input  slot_t                       ex_q,
    input  wb_t                         wb_q,
    output logic [N_SRC-1:0][SEL_W-1:0] sel
);

    for (genvar k = 0; k < N_SRC; k++) begin : g_port
        assign sel[k] = pick_src(fwd_en, rr_q.use_rs[k], rr_q.rs[k], ex_q, wb_q);
    end

endmodule

// File: rtl/phc_flow_ctrl.sv
module phc_flow_ctrl
    import phc_pkg::*;
(
    input  logic  delay_mode,
    input  slot_t ex_q,
    input  logic  ex_cond,
    input  logic  data_stall,
    input  logic  port_busy,
    output logic  redirect,
    output logic  hold_fetch,
    output logic  hold_dec,
    output logic  kill_if,
    output logic  kill_dec,
    output logic  kill_rr
);

    logic taken;

    always_comb begin
        taken      = ex_q.vld & ex_q.br & ex_cond;
        redirect   = taken;
        // a redirect overrides every hold: younger work is dropped anyway
        hold_fetch = (data_stall | port_busy) & ~taken;
        hold_dec   = data_stall & ~taken;
        kill_if    = taken | port_busy;
        kill_dec   = taken | data_stall;
        kill_rr    = taken & ~delay_mode;
    end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import phc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fwd_en,
    input  logic             delay_mode,
    input  logic             if_valid,
    input  logic [TAG_W-1:0] if_tag,
    input  logic [RA_W-1:0]  if_rs1,
    input  logic             if_use1,
    input  logic [RA_W-1:0]  if_rs2,
    input  logic             if_use2,
    input  logic [RA_W-1:0]  if_rd,
    input  logic             if_we,
    input  logic             if_late,
    input  logic             if_mem,
    input  logic             if_br,
    input  logic             ex_cond,
    output logic             hold_fetch,
    output logic             redirect,
    output logic [SEL_W-1:0] fwd_a,
    output logic [SEL_W-1:0] fwd_b,
    output logic             wb_valid,
    output logic [TAG_W-1:0] wb_tag,
    output logic [RA_W-1:0]  wb_rd,
    output logic             wb_we
);

    slot_t if_slot;
    slot_t id_q;
    slot_t rr_q;
    slot_t ex_q;
    wb_t   wb_q;

    logic data_stall;
    logic port_busy;
    logic hold_dec;
    logic kill_if;
    logic kill_dec;
    logic kill_rr;
    logic [N_SRC-1:0][SEL_W-1:0] sel;

    always_comb begin
        if_slot           = '0;
        if_slot.vld       = if_valid;
        if_slot.tag       = if_tag;
        if_slot.rs[0]     = if_rs1;
        if_slot.rs[1]     = if_rs2;
        if_slot.use_rs[0] = if_use1 & if_valid;
        if_slot.use_rs[1] = if_use2 & if_valid;
        if_slot.rd        = if_rd;
        if_slot.we        = if_we & if_valid;
        if_slot.late      = if_late & if_valid;
        if_slot.mem       = if_mem & if_valid;
        if_slot.br        = if_br & if_valid;
    end

    phc_stage_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .if_slot  (if_slot),
        .hold_dec (hold_dec),
        .kill_if  (kill_if),
        .kill_dec (kill_dec),
        .kill_rr  (kill_rr),
        .id_q     (id_q),
        .rr_q     (rr_q),
        .ex_q     (ex_q),
        .wb_q     (wb_q)
    );

    phc_stall_unit u_stall (
        .fwd_en     (fwd_en),
        .id_q       (id_q),
        .rr_q       (rr_q),
        .ex_q       (ex_q),
        .data_stall (data_stall),
        .port_busy  (port_busy)
    );

    phc_fwd_unit u_fwd (
        .fwd_en (fwd_en),
        .rr_q   (rr_q),
        .ex_q   (ex_q),
        .wb_q   (wb_q),
        .sel    (sel)
    );

    phc_flow_ctrl u_flow (
        .delay_mode (delay_mode),
        .ex_q       (ex_q),
        .ex_cond    (ex_cond),
        .data_stall (data_stall),
        .port_busy  (port_busy),
        .redirect   (redirect),
        .hold_fetch (hold_fetch),
        .hold_dec   (hold_dec),
        .kill_if    (kill_if),
        .kill_dec   (kill_dec),
        .kill_rr    (kill_rr)
    );

    assign fwd_a    = sel[0];
    assign fwd_b    = sel[1];
    assign wb_valid = wb_q.vld;
    assign wb_tag   = wb_q.tag;
    assign wb_rd    = wb_q.rd;
    assign wb_we    = wb_q.we;

endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk
    import phc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             fwd_en,
    input logic             delay_mode,
    input logic             hold_fetch,
    input logic             redirect,
    input logic [SEL_W-1:0] fwd_a,
    input logic [SEL_W-1:0] fwd_b,
    input slot_t            id_q,
    input slot_t            rr_q,
    input slot_t            ex_q
);

    // R9
    squash_all_chk: assert property (@(posedge clk) disable iff (rst)
        (redirect && !delay_mode) |=> (!id_q.vld && !rr_q.vld && !ex_q.vld));

    // R10
    slot_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (redirect && delay_mode) |=> (!id_q.vld && !rr_q.vld && ex_q == $past(rr_q)));

    // R3
    no_fwd_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !fwd_en |-> (fwd_a == SRC_RF && fwd_b == SRC_RF));

    // R8
    port_user_blocks_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_q.vld && ex_q.mem && !redirect) |-> hold_fetch);

    // R3
    decode_held_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_fetch && !(ex_q.vld && ex_q.mem)) |=> ($stable(id_q) && !rr_q.vld));

    // R7
    r0_never_fwd_a_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_a != SRC_RF) |-> (rr_q.rs[0] != '0));

    // R7
    r0_never_fwd_b_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_b != SRC_RF) |-> (rr_q.rs[1] != '0));

    // R9
    redirect_beats_hold_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |-> !hold_fetch);

endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .fwd_en     (fwd_en),
    .delay_mode (delay_mode),
    .hold_fetch (hold_fetch),
    .redirect   (redirect),
    .fwd_a      (fwd_a),
    .fwd_b      (fwd_b),
    .id_q       (id_q),
    .rr_q       (rr_q),
    .ex_q       (ex_q)
);

// File: tb/test_pipe_hazard_ctrl.sv
module test_pipe_hazard_ctrl;
    import phc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fwd_en = 1'b0;
    logic delay_mode = 1'b0;
    logic if_valid = 1'b0;
    logic [TAG_W-1:0] if_tag = '0;
    logic [RA_W-1:0] if_rs1 = '0;
    logic if_use1 = 1'b0;
    logic [RA_W-1:0] if_rs2 = '0;
    logic if_use2 = 1'b0;
    logic [RA_W-1:0] if_rd = '0;
    logic if_we = 1'b0;
    logic if_late = 1'b0;
    logic if_mem = 1'b0;
    logic if_br = 1'b0;
    logic ex_cond = 1'b0;
    logic hold_fetch;
    logic redirect;
    logic [SEL_W-1:0] fwd_a;
    logic [SEL_W-1:0] fwd_b;
    logic wb_valid;
    logic [TAG_W-1:0] wb_tag;
    logic [RA_W-1:0] wb_rd;
    logic wb_we;

    always #5 clk = ~clk;

    pipe_hazard_ctrl i_pipe_hazard_ctrl (
        .clk(clk), .rst(rst), .fwd_en(fwd_en), .delay_mode(delay_mode),
        .if_valid(if_valid), .if_tag(if_tag), .if_rs1(if_rs1), .if_use1(if_use1),
        .if_rs2(if_rs2), .if_use2(if_use2), .if_rd(if_rd), .if_we(if_we),
        .if_late(if_late), .if_mem(if_mem), .if_br(if_br), .ex_cond(ex_cond),
        .hold_fetch(hold_fetch), .redirect(redirect), .fwd_a(fwd_a), .fwd_b(fwd_b),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_rd(wb_rd), .wb_we(wb_we)
    );

    localparam int PMAX = 32;

    // program: one descriptor per instruction
    int p_rd [PMAX];
    int p_we [PMAX];
    int p_s1 [PMAX];
    int p_u1 [PMAX];
    int p_s2 [PMAX];
    int p_u2 [PMAX];
    int p_late [PMAX];
    int p_mem [PMAX];
    int p_br [PMAX];
    int plen;
    int br_target;

    int ret_cyc [PMAX];
    int fa_log [PMAX];
    int fb_log [PMAX];
    int hold_log [PMAX];
    int redir_log [PMAX];

    int n_chk = 0;
    int n_bad = 0;
    int total_cyc = 0;

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < PMAX; i++) begin
            p_rd[i] = 0; p_we[i] = 0; p_s1[i] = 0; p_u1[i] = 0;
            p_s2[i] = 0; p_u2[i] = 0; p_late[i] = 0; p_mem[i] = 0; p_br[i] = 0;
        end
        br_target = 0;
    endtask

    task automatic drive(input int pc);
        if (pc < plen) begin
            if_valid = 1'b1;
            if_tag   = TAG_W'(pc);
            if_rd    = RA_W'(p_rd[pc]);
            if_we    = p_we[pc][0];
            if_rs1   = RA_W'(p_s1[pc]);
            if_use1  = p_u1[pc][0];
            if_rs2   = RA_W'(p_s2[pc]);
            if_use2  = p_u2[pc][0];
            if_late  = p_late[pc][0];
            if_mem   = p_mem[pc][0];
            if_br    = p_br[pc][0];
        end else begin
            if_valid = 1'b0; if_tag = '0; if_rd = '0; if_we = 1'b0;
            if_rs1 = '0; if_use1 = 1'b0; if_rs2 = '0; if_use2 = 1'b0;
            if_late = 1'b0; if_mem = 1'b0; if_br = 1'b0;
        end
    endtask

    // cycle 0 is the first cycle after reset, in which instruction 0 is at fetch
    task automatic run_prog(input int ncyc);
        int pc;
        pc = 0;
        rst = 1'b1;
        drive(PMAX);
        for (int i = 0; i < PMAX; i++) begin
            ret_cyc[i] = -1; fa_log[i] = 0; fb_log[i] = 0; hold_log[i] = 0; redir_log[i] = 0;
        end
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            drive(pc);
            @(negedge clk);
            fa_log[c]    = int'(fwd_a);
            fb_log[c]    = int'(fwd_b);
            hold_log[c]  = int'(hold_fetch);
            redir_log[c] = int'(redirect);
            if (wb_valid && int'(wb_tag) < PMAX) ret_cyc[int'(wb_tag)] = c;
            if (redirect) pc = br_target;
            else if (!hold_fetch) pc++;
            @(posedge clk);
            #1;
        end
    endtask

    always @(posedge clk) begin
        total_cyc++;
        if (total_cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=%0d exp=%0d", total_cyc, 100000);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int r;
        int s;
        int cr;
        int ef;
        int got_sel;
        int oth_sel;
        int any;
        string tag;

        // R1: reset state with a writing branch driven at fetch
        plen = 1;
        clear_prog();
        p_rd[0] = 4; p_we[0] = 1; p_br[0] = 1; p_mem[0] = 1;
        rst = 1'b1;
        ex_cond = 1'b1;
        fwd_en = 1'b1;
        drive(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 wb_valid", int'(wb_valid), 0);
        check("R1 hold_fetch", int'(hold_fetch), 0);
        check("R1 redirect", int'(redirect), 0);
        check("R1 fwd_a", int'(fwd_a), 0);
        check("R1 fwd_b", int'(fwd_b), 0);
        @(posedge clk);
        #1 rst = 1'b0;
        drive(PMAX);
        @(negedge clk);
        check("R1 empty after release", int'(wb_valid) + int'(hold_fetch) + int'(redirect), 0);

        // R2 and R11: independent straight-line code, ex_cond high, no branch
        clear_prog();
        plen = 8;
        for (int i = 0; i < 8; i++) begin p_rd[i] = i + 1; p_we[i] = 1; end
        fwd_en = 1'b1; delay_mode = 1'b0; ex_cond = 1'b1;
        run_prog(16);
        for (int i = 0; i < 8; i++) check("R2 retire cycle", ret_cyc[i], i + 4);
        any = 0;
        for (int c = 0; c < 16; c++) any += redir_log[c] + hold_log[c];
        check("R11 no redirect without branch", any, 0);

        // R3 R4 R5 R7: sweep distance, port, forwarding, late result, r0
        for (int f = 0; f < 2; f++) begin
            for (int l = 0; l < 2; l++) begin
                for (int d = 1; d <= 4; d++) begin
                    for (int z = 0; z < 2; z++) begin
                        for (int p = 0; p < 2; p++) begin
                            clear_prog();
                            fwd_en = f[0]; delay_mode = 1'b0; ex_cond = 1'b0;
                            r = (z != 0) ? 0 : 7;
                            p_rd[0] = r; p_we[0] = 1; p_late[0] = l;
                            if (p == 0) begin p_s1[d] = r; p_u1[d] = 1; p_s2[d] = 9; end
                            else begin p_s2[d] = r; p_u2[d] = 1; p_s1[d] = 9; end
                            p_rd[d + 1] = 3; p_we[d + 1] = 1;
                            plen = d + 2;
                            run_prog(20);
                            if (z != 0) s = 0;
                            else if (f != 0) s = (l != 0 && d == 1) ? 1 : 0;
                            else s = (d < 3) ? 3 - d : 0;
                            cr = d + 2 + s;
                            if (z != 0 || f == 0) ef = 0;
                            else if (cr == 3) ef = 1;
                            else if (cr == 4) ef = 2;
                            else ef = 0;
                            if (z != 0) tag = "R7";
                            else if (f == 0) tag = "R3";
                            else if (l != 0 && d == 1) tag = "R5";
                            else tag = "R4";
                            got_sel = (p == 0) ? fa_log[cr] : fb_log[cr];
                            oth_sel = (p == 0) ? fb_log[cr] : fa_log[cr];
                            check({tag, " consumer retire"}, ret_cyc[d], d + 4 + s);
                            check({tag, " tail retire"}, ret_cyc[d + 1], d + 5 + s);
                            check({tag, " select used port"}, got_sel, ef);
                            check({tag, " select other port"}, oth_sel, 0);
                        end
                    end
                end
            end
        end

        // R6: two producers of r9, youngest wins
        clear_prog();
        fwd_en = 1'b1; ex_cond = 1'b0;
        p_rd[0] = 9; p_we[0] = 1; p_rd[1] = 9; p_we[1] = 1;
        p_s1[2] = 9; p_u1[2] = 1; p_s2[2] = 9; p_u2[2] = 1;
        plen = 3;
        run_prog(12);
        check("R6 youngest on port a", fa_log[4], 1);
        check("R6 youngest on port b", fb_log[4], 1);
        clear_prog();
        p_rd[0] = 9; p_we[0] = 1; p_rd[1] = 10; p_we[1] = 1;
        p_s1[2] = 9; p_u1[2] = 1;
        plen = 3;
        run_prog(12);
        check("R6 older only gives writeback", fa_log[4], 2);

        // R8: shared-port user at index 1 blocks the fetch of index 4
        clear_prog();
        fwd_en = 1'b1;
        for (int i = 0; i < 6; i++) begin p_rd[i] = 20 + i; p_we[i] = 1; end
        p_mem[1] = 1;
        plen = 6;
        run_prog(16);
        check("R8 hold raised", hold_log[4], 1);
        check("R8 no hold before", hold_log[3], 0);
        check("R8 earlier retire", ret_cyc[3], 7);
        check("R8 replayed fetch", ret_cyc[4], 9);
        check("R8 following", ret_cyc[5], 10);

        // R9 R12: squash mode, branch at 1, target 8, wrong path writes r5
        for (int f = 0; f < 2; f++) begin
            clear_prog();
            fwd_en = f[0]; delay_mode = 1'b0; ex_cond = 1'b1;
            for (int i = 0; i < 12; i++) begin p_rd[i] = 12; p_we[i] = 0; end
            p_br[1] = 1; br_target = 8;
            p_rd[2] = 5; p_we[2] = 1; p_rd[3] = 5; p_we[3] = 1; p_rd[4] = 5; p_we[4] = 1;
            p_s1[8] = 5; p_u1[8] = 1; p_s2[9] = 5; p_u2[9] = 1;
            plen = 12;
            run_prog(20);
            check("R9 redirect", redir_log[4], 1);
            check("R9 branch retires", ret_cyc[1], 5);
            check("R9 killed 2", ret_cyc[2], -1);
            check("R9 killed 3", ret_cyc[3], -1);
            check("R9 killed 4", ret_cyc[4], -1);
            check("R12 target not stalled", ret_cyc[8], 9);
            check("R12 no forward a", fa_log[7], 0);
            check("R12 no forward b", fb_log[8], 0);
        end

        // R10: delayed mode keeps the slot
        clear_prog();
        fwd_en = 1'b1; delay_mode = 1'b1; ex_cond = 1'b1;
        p_br[1] = 1; br_target = 8;
        p_rd[2] = 5; p_we[2] = 1; p_rd[3] = 6; p_we[3] = 1;
        plen = 12;
        run_prog(20);
        check("R10 redirect", redir_log[4], 1);
        check("R10 slot retires", ret_cyc[2], 6);
        check("R10 killed 3", ret_cyc[3], -1);
        check("R10 killed 4", ret_cyc[4], -1);
        check("R10 target", ret_cyc[8], 9);

        // R11: branch with ex_cond low drops nothing
        clear_prog();
        fwd_en = 1'b1; delay_mode = 1'b0; ex_cond = 1'b0;
        p_br[1] = 1; br_target = 8;
        plen = 12;
        run_prog(20);
        any = 0;
        for (int c = 0; c < 20; c++) any += redir_log[c];
        check("R11 no redirect", any, 0);
        for (int i = 0; i < 12; i++) check("R11 all retire", ret_cyc[i], i + 4);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule